// File: doc/BRIEF.md
# Window Comparison Host Sequencer

This block is the host side of a serial threshold comparator. The comparator is a device that takes a short programming frame and then reports one comparison bit per clock. A start request brings a 3-bit input-selection word and two 8-bit limits. The sequencer then programs the comparator twice, once with the lower limit and once with the upper limit. From each programming it takes one trustworthy comparison bit. It combines the two bits into a two-bit zone code and marks the result with a one-clock done pulse.

The comparator shares the sequencer's free-running clock. It captures the serial data line on rising edges and moves its result line only on falling edges, so the sequencer changes its outputs and samples the result on rising edges. Dropping the select line starts a programming frame. Raising it erases everything the comparator holds. For that reason the two comparisons are separated by an idle interval, with a configurable length, during which the select line is high.

Top module: `window_cmp_seq`

## Requirements
- R1: After reset, `cs_n_o` is 1 and `sdi_o`, `busy_o`, `done_o` and `zone_o` are 0.
- R2: Each frame places one bit per clock on `sdi_o`, changed only at rising edges, in this order: a 1, the three bits of `mode_i` from bit 2 down to bit 0, then the eight limit bits from bit 0 up to bit 7.
- R3: The first frame carries `lo_lim_i` and the second carries `hi_lim_i`. Both carry the same `mode_i`, captured with the request. `cs_n_o` stays low from the first bit of a frame until that frame's result is sampled.
- R4: The sequencer samples `sdo_i` at the second rising edge after the edge where the comparator captures the last frame bit, plus `SETTLE_EXTRA` further edges. With the default parameters this is the 14th rising edge after the edge that starts the frame.
- R5: Between the two frames `cs_n_o` is high for exactly `GAP_CLKS` clock cycles, and `GAP_CLKS` must be at least 1.
- R6: With L the bit sampled in the lower-limit frame and H the bit sampled in the upper-limit frame, `zone_o` is 00 when L=0 and H=0 (below), 01 when L=1 and H=0 (inside), 10 when L=1 and H=1 (above), and 11 when L=0 and H=1 (inconsistent limits).
- R7: `done_o` is high for exactly one clock per request. `zone_o` changes only in the cycle `done_o` rises and holds its value until the next done.
- R8: A `start_i` seen while `busy_o` is high has no effect. The frames, the result and the number of done pulses all belong to the accepted request.
- R9: With default parameters, `done_o` is high in the cycle after the 30th rising edge following the edge that accepts the start, that is 2*(FRAME+2+SETTLE_EXTRA)+GAP_CLKS edges with FRAME=12.
- R10: `sdi_o` is 0 whenever `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock shared with the comparator |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a window classification (taken only when idle) |
| mode_i | input | MODE_W | Input-selection word sent in both frames |
| lo_lim_i | input | LIM_W | Lower window limit |
| hi_lim_i | input | LIM_W | Upper window limit |
| cs_n_o | output | 1 | Active-low select to the comparator |
| sdi_o | output | 1 | Serial programming data to the comparator |
| sdo_i | input | 1 | Comparison result from the comparator |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-clock pulse: `zone_o` is updated |
| zone_o | output | 2 | Window classification code |

## Verification
If the bit counter is off by one, the comparator latches a shifted limit or a shifted selection word. The wrong threshold or channel shows up as a wrong zone code after about 30 clocks. A sample point placed one edge too early catches the comparator's undefined interval, which is modelled as the inverted answer, so every request gives a wrong zone. A state machine that restarts on a request made while busy shows up at once, either as frames carrying the second request's limits or as an extra done pulse.

// File: rtl/wcs_pkg.sv
`timescale 1ns/1ps
package wcs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_GAP   = 2'd2
   } seq_state_e;

   localparam logic [1:0] ZONE_BELOW  = 2'b00;
   localparam logic [1:0] ZONE_INSIDE = 2'b01;
   localparam logic [1:0] ZONE_ABOVE  = 2'b10;
   localparam logic [1:0] ZONE_SPLIT  = 2'b11;
endpackage

// File: rtl/wcs_frame_tx.sv
`timescale 1ns/1ps
module wcs_frame_tx #(
   parameter int MODE_W       = 3,
   parameter int LIM_W        = 8,
   parameter int SETTLE_EXTRA = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [LIM_W-1:0]  lim_i,
   output logic              sdi_o,
   output logic              sample_o
);
   localparam int FRAME_LEN   = 1 + MODE_W + LIM_W;
   localparam int SAMPLE_TICK = FRAME_LEN + 1 + SETTLE_EXTRA;
   localparam int TICK_W      = $clog2(SAMPLE_TICK + 1);

   logic [FRAME_LEN-1:0] frame_w;
   logic [FRAME_LEN-1:0] sr_q;
   logic [TICK_W-1:0]    tick_q;
   logic                 active_q;

   // bit 0 goes out first: marker, selection word high bit first, limit low bit first
   assign frame_w[0] = 1'b1;
   generate
      for (genvar i = 0; i < MODE_W; i++) begin : g_mode
         assign frame_w[1+i] = mode_i[MODE_W-1-i];
      end
      for (genvar j = 0; j < LIM_W; j++) begin : g_lim
         assign frame_w[1+MODE_W+j] = lim_i[j];
      end
   endgenerate

   assign sample_o = active_q && (tick_q == TICK_W'(SAMPLE_TICK));
   assign sdi_o    = sr_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q     <= '0;
         tick_q   <= '0;
         active_q <= 1'b0;
      end else if (load_i) begin
         sr_q     <= frame_w;
         tick_q   <= '0;
         active_q <= 1'b1;
      end else if (active_q) begin
         sr_q <= sr_q >> 1;
         if (sample_o) begin
            active_q <= 1'b0;
            tick_q   <= '0;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   assert_one_bit_per_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !sample_o && !load_i) |=> (tick_q == $past(tick_q) + 1'b1));

   assert_no_reload_in_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !active_q);

   assert_sample_after_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> (tick_q > TICK_W'(FRAME_LEN)));
endmodule

// File: rtl/wcs_gap_timer.sv
`timescale 1ns/1ps
module wcs_gap_timer #(
   parameter int GAP_CLKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   output logic expire_o
);
   localparam int GAP_W = $clog2(GAP_CLKS + 1);

   logic [GAP_W-1:0] cnt_q;
   logic             run_q;

   assign expire_o = run_q && (cnt_q == GAP_W'(GAP_CLKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (arm_i) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (expire_o) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assert_gap_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q < GAP_W'(GAP_CLKS)));
endmodule

// File: rtl/wcs_classify.sv
`timescale 1ns/1ps
module wcs_classify (
   input  logic       lo_hit_i,
   input  logic       hi_hit_i,
   output logic [1:0] zone_o
);
   always_comb begin
      unique case ({lo_hit_i, hi_hit_i})
         2'b00:   zone_o = wcs_pkg::ZONE_BELOW;
         2'b10:   zone_o = wcs_pkg::ZONE_INSIDE;
         2'b11:   zone_o = wcs_pkg::ZONE_ABOVE;
         default: zone_o = wcs_pkg::ZONE_SPLIT;
      endcase
   end
endmodule

// File: rtl/window_cmp_seq.sv
`timescale 1ns/1ps
module window_cmp_seq #(
   parameter int MODE_W       = 3,
   parameter int LIM_W        = 8,
   parameter int GAP_CLKS     = 2,
   parameter int SETTLE_EXTRA = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [LIM_W-1:0]  lo_lim_i,
   input  logic [LIM_W-1:0]  hi_lim_i,
   output logic              cs_n_o,
   output logic              sdi_o,
   input  logic              sdo_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [1:0]        zone_o
);
   import wcs_pkg::*;

   generate
      if (GAP_CLKS < 1) begin : g_bad_gap
         $error("GAP_CLKS must be at least 1");
      end
      if (MODE_W < 1 || LIM_W < 1) begin : g_bad_width
         $error("MODE_W and LIM_W must be positive");
      end
      if (SETTLE_EXTRA < 0) begin : g_bad_settle
         $error("SETTLE_EXTRA must not be negative");
      end
   endgenerate

   seq_state_e        state_q;
   logic              phase_q;
   logic              lo_res_q;
   logic [MODE_W-1:0] mode_q;
   logic [LIM_W-1:0]  hi_q;
   logic              cs_n_q;
   logic              done_q;
   logic [1:0]        zone_q;

   logic              load_w;
   logic              sample_w;
   logic              arm_w;
   logic              gap_exp_w;
   logic [MODE_W-1:0] mode_sel_w;
   logic [LIM_W-1:0]  lim_sel_w;
   logic [1:0]        zone_w;

   assign load_w     = ((state_q == ST_IDLE) && start_i) || ((state_q == ST_GAP) && gap_exp_w);
   assign mode_sel_w = (state_q == ST_IDLE) ? mode_i   : mode_q;
   assign lim_sel_w  = (state_q == ST_IDLE) ? lo_lim_i : hi_q;
   assign arm_w      = (state_q == ST_FRAME) && sample_w && !phase_q;

   wcs_frame_tx #(
      .MODE_W      (MODE_W),
      .LIM_W       (LIM_W),
      .SETTLE_EXTRA(SETTLE_EXTRA)
   ) i_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_w),
      .mode_i  (mode_sel_w),
      .lim_i   (lim_sel_w),
      .sdi_o   (sdi_o),
      .sample_o(sample_w)
   );

   wcs_gap_timer #(.GAP_CLKS(GAP_CLKS)) i_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_i   (arm_w),
      .expire_o(gap_exp_w)
   );

   wcs_classify i_cls (
      .lo_hit_i(lo_res_q),
      .hi_hit_i(sdo_i),
      .zone_o  (zone_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         phase_q  <= 1'b0;
         lo_res_q <= 1'b0;
         mode_q   <= '0;
         hi_q     <= '0;
         cs_n_q   <= 1'b1;
         done_q   <= 1'b0;
         zone_q   <= ZONE_BELOW;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q  <= mode_i;
                  hi_q    <= hi_lim_i;
                  cs_n_q  <= 1'b0;
                  phase_q <= 1'b0;
                  state_q <= ST_FRAME;
               end
            end
            ST_FRAME: begin
               if (sample_w) begin
                  cs_n_q <= 1'b1;
                  if (!phase_q) begin
                     lo_res_q <= sdo_i;
                     state_q  <= ST_GAP;
                  end else begin
                     zone_q  <= zone_w;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_GAP: begin
               if (gap_exp_w) begin
                  cs_n_q  <= 1'b0;
                  phase_q <= 1'b1;
                  state_q <= ST_FRAME;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n_o = cs_n_q;
   assign done_o = done_q;
   assign zone_o = zone_q;
   assign busy_o = (state_q != ST_IDLE);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_zone_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(zone_o));

   assert_sdi_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sdi_o);

   assert_cs_low_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FRAME) |-> !cs_n_o);

   assert_busy_during_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP) |-> (cs_n_o && busy_o));
endmodule

// File: tb/test_window_cmp_seq.sv
`timescale 1ns/1ps
module test_window_cmp_seq;
   localparam int MODE_W = 3;
   localparam int LIM_W = 8;
   localparam int GAP = 2;
   localparam int SETTLE = 0;
   localparam int FRAME = 1 + MODE_W + LIM_W;
   localparam int EXP_LAT = 2 * (FRAME + 2 + SETTLE) + GAP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [2:0] mode_i = '0;
   logic [7:0] lo_lim_i = '0;
   logic [7:0] hi_lim_i = '0;
   logic cs_n, sdi, sdo, busy, done;
   logic [1:0] zone;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   window_cmp_seq #(.MODE_W(MODE_W), .LIM_W(LIM_W), .GAP_CLKS(GAP), .SETTLE_EXTRA(SETTLE))
   i_window_cmp_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .lo_lim_i(lo_lim_i), .hi_lim_i(hi_lim_i), .cs_n_o(cs_n), .sdi_o(sdi),
      .sdo_i(sdo), .busy_o(busy), .done_o(done), .zone_o(zone)
   );

   // ---------------- comparator device model ----------------
   logic [7:0] lev [8];
   logic       dev_started = 1'b0;
   logic       dev_prog = 1'b0;
   int         dev_cnt = 0;
   int         dev_neg = 0;
   logic [2:0] dev_mux = '0;
   logic [7:0] dev_code = '0;
   logic       do_q = 1'b0;
   int         frames_total = 0;
   logic [2:0] mux_prev = '0, mux_last = '0;
   logic [7:0] code_prev = '0, code_last = '0;

   assign sdo = do_q;

   always @(posedge clk) begin
      if (cs_n) begin
         dev_started <= 1'b0;
         dev_prog    <= 1'b0;
         dev_cnt     <= 0;
      end else if (!dev_prog) begin
         if (!dev_started) begin
            if (sdi) begin
               dev_started <= 1'b1;
               dev_cnt     <= 0;
            end
         end else begin
            if (dev_cnt < 3) dev_mux <= {dev_mux[1:0], sdi};
            else             dev_code <= {sdi, dev_code[7:1]};
            dev_cnt <= dev_cnt + 1;
            if (dev_cnt == 10) dev_prog <= 1'b1;
         end
      end
   end

   always @(negedge clk) begin
      if (cs_n || !dev_prog) begin
         dev_neg <= 0;
         do_q    <= 1'b0;
      end else begin
         if (dev_neg == 0) begin
            do_q         <= ~(lev[dev_mux] > dev_code); // undefined interval: wrong answer
            mux_prev     <= mux_last;
            code_prev    <= code_last;
            mux_last     <= dev_mux;
            code_last    <= dev_code;
            frames_total <= frames_total + 1;
         end else begin
            do_q <= (lev[dev_mux] > dev_code);
         end
         if (dev_neg < 1000) dev_neg <= dev_neg + 1;
      end
   end

   // ---------------- monitors ----------------
   int hi_run = 0;
   int last_gap = 0;
   int quiet_err = 0;
   int done_cnt = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (cs_n) hi_run <= hi_run + 1;
         else begin
            if (hi_run > 0) last_gap <= hi_run;
            hi_run <= 0;
         end
         if (cs_n && sdi) quiet_err <= quiet_err + 1;
         if (done) done_cnt <= done_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_zone(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
      logic l, h;
      l = v > lo;
      h = v > hi;
      if (!l && !h)     return 2'b00;
      else if (l && !h) return 2'b01;
      else if (l && h)  return 2'b10;
      else              return 2'b11;
   endfunction

   task automatic run_trial(input logic [2:0] m, input logic [7:0] lo, input logic [7:0] hi,
                            input bit poke);
      int n;
      int f0;
      int d0;
      logic [1:0] ez;
      ez = exp_zone(lev[m], lo, hi);
      f0 = frames_total;
      @(negedge clk);
      d0 = done_cnt;
      mode_i = m; lo_lim_i = lo; hi_lim_i = hi; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      if (poke) begin
         mode_i = ~m; lo_lim_i = ~lo; hi_lim_i = ~hi; start_i = 1'b1;
      end
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
         if (n == 20) start_i = 1'b0;
      end
      start_i = 1'b0;
      check(done, "R9 done seen", int'(done), 1);
      check(n - 1 == EXP_LAT, "R9 latency", n - 1, EXP_LAT);
      check(zone == ez, "R6 zone", int'(zone), int'(ez));
      check(frames_total - f0 == 2, "R3 frame count", frames_total - f0, 2);
      check(code_prev == lo, "R3 lower limit frame", int'(code_prev), int'(lo));
      check(code_last == hi, "R3 upper limit frame", int'(code_last), int'(hi));
      check(mux_prev == m && mux_last == m, "R2 mode word", int'(mux_last), int'(m));
      check(last_gap == GAP, "R5 gap length", last_gap, GAP);
      @(negedge clk);
      check(!done, "R7 done one clock", int'(done), 0);
      check(zone == ez, "R7 zone held", int'(zone), int'(ez));
      check(!busy && cs_n, "R8 idle after done", int'(busy), 0);
      if (poke) begin
         repeat (40) @(negedge clk);
         check(done_cnt - d0 == 1, "R8 busy start ignored", done_cnt - d0, 1);
         check(frames_total - f0 == 2, "R8 no extra frame", frames_total - f0, 2);
      end
   endtask

   bit finished = 1'b0;

   initial begin
      void'($urandom(32'h5eed_0a11));
      for (int i = 0; i < 8; i++) lev[i] = 8'(i * 30 + 5);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cs_n == 1'b1, "R1 reset cs_n", int'(cs_n), 1);
      check(sdi == 1'b0 && busy == 1'b0, "R1 reset sdi/busy", int'(sdi), 0);
      check(done == 1'b0 && zone == 2'b00, "R1 reset done/zone", int'(zone), 0);

      // directed corner cases
      lev[3] = 8'd50;
      run_trial(3'd3, 8'd50, 8'd100, 1'b0);   // equal to lower: below
      lev[3] = 8'd51;
      run_trial(3'd3, 8'd50, 8'd100, 1'b0);   // just inside
      lev[5] = 8'd100;
      run_trial(3'd5, 8'd50, 8'd100, 1'b0);   // equal to upper: inside
      lev[5] = 8'd101;
      run_trial(3'd5, 8'd50, 8'd100, 1'b0);   // above
      lev[6] = 8'd100;
      run_trial(3'd6, 8'd200, 8'd50, 1'b0);   // inverted limits: split code
      lev[7] = 8'd255;
      run_trial(3'd7, 8'd0, 8'd255, 1'b0);
      lev[0] = 8'd0;
      run_trial(3'd0, 8'd0, 8'd255, 1'b0);
      lev[1] = 8'd128;
      run_trial(3'd1, 8'd10, 8'd240, 1'b1);   // start held while busy

      for (int t = 0; t < 40; t++) begin
         logic [2:0] m;
         logic [7:0] a, b;
         m = 3'($urandom);
         a = 8'($urandom);
         b = 8'($urandom);
         lev[m] = 8'($urandom);
         if ((t % 4) != 0 && a > b) begin
            logic [7:0] s;
            s = a; a = b; b = s;
         end
         run_trial(m, a, b, (t % 10) == 9);
      end
      check(quiet_err == 0, "R10 sdi low while deselected", quiet_err, 0);
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (150000) @(posedge clk);
            check(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule